// File: doc/BRIEF.md
# Power Mode Control Register

This block is the single control and status register of a small microcontroller power manager. Software reads and writes it over a simple 32-bit register bus. When the core issues a sleep request, the block works out which reduced-power mode to enter and offers that mode to the power manager. It then waits a bounded time for an acknowledge. If the acknowledge arrives in time, it records the entered mode in a sticky status flag. Until a wake event, it tracks that the chip is in a low-power state.

The register also drives the brown-out detector. One field switches the detector off completely. A second field switches it off only in the deeper sleep states, and that also removes it as a wake source. A third field keeps a brown-out from resetting the chip while still letting its interrupt through. Switching the detector on or off is guarded: the change is refused unless brown-out reset is disabled and the brown-out interrupt is masked, and a refused change raises a sticky error bit.

The mode-entry flags live in two reset domains. The three shallower flags are cleared by the core reset (core power-up or brown-out). The deepest-mode flag is cleared only by the backup-supply reset, so it survives a wake from the deepest mode.

Top module: `powerModeUnit`

## Requirements
- R1: After both resets the register reads 0x0000_0000, `pwrReq` and `lowPowerActive` are low, and `bodEnOut` is high.
- R2: Mode selection uses field `[1:0]`. Value 00 gives Sleep (mode code 0) when `deepSleepIn` is low and Deep Sleep (code 1) when it is high. Value 01 gives Power-down (code 2). Values 10 and 11 give Deep Power-down (code 3). The selected code is latched on `sleepReq` and shown on `pwrMode` while `pwrReq` is high.
- R3: A request is acknowledged if `pwrAck` is high on any of the 16 clock edges after the edge that accepted `sleepReq`. An acknowledged request sets flag bit 8+code and raises `lowPowerActive` until `wakeIn`. Without an acknowledge, `pwrReq` drops after the 16th edge and no flag changes.
- R4: Flag bits 11:8 are one-hot or all zero. Setting a flag clears the other three.
- R5: Writing a one to a flag bit clears it. Writing a zero to a flag bit has no effect.
- R6: The core reset clears bits 10:8 and bits 5:0 but not bit 11. The backup reset clears only bit 11.
- R7: While bit 3 is 1, `bodEnOut`, `bodWakeEnOut`, `bodRstOut` and `bodIrqOut` are all low.
- R8: While bit 2 is 1 and the chip is in Deep Sleep or Power-down, `bodEnOut` and `bodWakeEnOut` are low. In Sleep or Deep Power-down, both stay high.
- R9: When bit 4 is 1, `bodDetect` does not raise `bodRstOut`, but `bodIrqOut` still follows `bodDetect` when `bodIrqEn` is high. When bit 4 is 0, `bodRstOut` follows `bodDetect`.
- R10: A write that would change bit 3 while bit 4 is 0 or `bodIrqEn` is high leaves bit 3 unchanged and sets sticky error bit 5. Writing a one to bit 5 clears it.
- R11: Bits 7:6 and 31:12 ignore writes and read as zero. `busRdata` is zero when the address does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstCoreN | input | 1 | Active-low core-domain reset (power-up or brown-out) |
| rstBackupN | input | 1 | Active-low backup-supply power-up reset |
| busSel | input | 1 | Bus access select |
| busWrite | input | 1 | Write strobe (with busSel) |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, zero when not addressed |
| sleepReq | input | 1 | Core sleep request pulse |
| deepSleepIn | input | 1 | Core selects Deep Sleep over Sleep |
| pwrAck | input | 1 | Power manager acknowledge |
| wakeIn | input | 1 | Wake event, leaves low-power state |
| pwrReq | output | 1 | Mode entry request to power manager |
| pwrMode | output | 2 | Requested or current mode code |
| lowPowerActive | output | 1 | Chip is in an acknowledged low-power mode |
| bodDetect | input | 1 | Brown-out detector trip |
| bodIrqEn | input | 1 | Brown-out interrupt enable |
| bodEnOut | output | 1 | Brown-out detector enable |
| bodWakeEnOut | output | 1 | Brown-out wake enable |
| bodRstOut | output | 1 | Brown-out reset request |
| bodIrqOut | output | 1 | Brown-out interrupt |

## Verification
The bench tests the last edge of the acknowledge window both ways. An acknowledge on the 16th edge must be taken, and silence through that edge must time out: an off-by-one counter would either drop valid entries or hold the request one cycle too long. It sets flags in both reset domains and pulses each reset alone, which catches a deepest-mode flag wired to the core reset or a shallow flag left sticky across it. It writes an on/off change to the detector under each blocking condition separately, so a guard that checks only one of them is caught. It also checks brown-out gating in all four modes, so a design that gates on the wrong pair of modes shows a wrong enable level.

// File: rtl/pmuPkg.sv
package pmuPkg;

  // Mode codes; the flag for a mode sits at FLAG_LSB + code
  typedef enum logic [1:0] {
    MODE_SLEEP  = 2'd0,
    MODE_DSLEEP = 2'd1,
    MODE_PDOWN  = 2'd2,
    MODE_DPDOWN = 2'd3
  } pmuMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     regWr;
    logic     setFlag;
    pmuMode_e flagMode;
  } pmuStrobe_t;

  localparam int PM_LSB    = 0;
  localparam int RPM_BIT   = 2;
  localparam int GDIS_BIT  = 3;
  localparam int RDIS_BIT  = 4;
  localparam int ERR_BIT   = 5;
  localparam int FLAG_LSB  = 8;
  localparam int NUM_FLAGS = 4;

endpackage

// File: rtl/pmuControl.sv
module pmuControl
  import pmuPkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hC0,
  parameter int ACK_WINDOW = 16
) (
  input  logic              clk,
  input  logic              rstCoreN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              sleepReq,
  input  logic              deepSleepIn,
  input  logic              pwrAck,
  input  logic              wakeIn,
  input  logic [1:0]        pmBits,
  output pmuStrobe_t        strobe,
  output logic              regHit,
  output logic              pwrReq,
  output pmuMode_e          curMode,
  output logic              lowPowerActive
);

  localparam int CNT_W = (ACK_WINDOW > 1) ? $clog2(ACK_WINDOW) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_WINDOW - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ASLEEP} ctlState_e;

  ctlState_e  state;
  logic [CNT_W-1:0] waitCnt;
  pmuMode_e   reqMode;

  assign regHit = busSel && (busAddr == REG_ADDR);

  // Mode selected by the control field and the core's deep-sleep hint
  always_comb begin
    if (pmBits[1])        reqMode = MODE_DPDOWN;
    else if (pmBits[0])   reqMode = MODE_PDOWN;
    else if (deepSleepIn) reqMode = MODE_DSLEEP;
    else                  reqMode = MODE_SLEEP;
  end

  always_ff @(posedge clk or negedge rstCoreN) begin
    if (!rstCoreN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      curMode <= MODE_SLEEP;
    end else begin
      unique case (state)
        ST_IDLE: if (sleepReq) begin
          state   <= ST_WAIT;
          waitCnt <= '0;
          curMode <= reqMode;
        end
        ST_WAIT: begin
          if (pwrAck)                   state <= ST_ASLEEP;
          else if (waitCnt == CNT_LAST) state <= ST_IDLE;
          else                          waitCnt <= waitCnt + 1'b1;
        end
        ST_ASLEEP: if (wakeIn) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pwrReq         = (state == ST_WAIT);
  assign lowPowerActive = (state == ST_ASLEEP);

  always_comb begin
    strobe          = '0;
    strobe.regWr    = regHit && busWrite;
    strobe.setFlag  = pwrReq && pwrAck;
    strobe.flagMode = curMode;
  end

  // Request withdrawn after the last window edge with no acknowledge
  assert_ack_window_R3: assert property (@(posedge clk) disable iff (!rstCoreN)
    (pwrReq && !pwrAck && waitCnt == CNT_LAST) |=> !pwrReq);

  // Flag set only together with an acknowledged open request
  assert_flag_on_ack_R3: assert property (@(posedge clk) disable iff (!rstCoreN)
    strobe.setFlag |-> (pwrAck && pwrReq));

  // Mode shown to the power manager holds while requested
  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rstCoreN)
    pwrReq |=> $stable(curMode));

endmodule

// File: rtl/pmuDatapath.sv
module pmuDatapath
  import pmuPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstCoreN,
  input  logic              rstBackupN,
  input  pmuStrobe_t        strobe,
  input  logic              regHit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lowPowerActive,
  input  pmuMode_e          curMode,
  input  logic              bodDetect,
  input  logic              bodIrqEn,
  output logic [1:0]        pmBits,
  output logic [DATA_W-1:0] rdata,
  output logic              bodEnOut,
  output logic              bodWakeEnOut,
  output logic              bodRstOut,
  output logic              bodIrqOut
);

  localparam int FLAG_MSB = FLAG_LSB + NUM_FLAGS - 1;

  logic rpmReg, gdisReg, rdisReg, errReg;
  logic guardTrip;
  logic [NUM_FLAGS-1:0] flags, flagsNext;
  logic unusedWdata;

  assign unusedWdata = ^{wdata[DATA_W-1:FLAG_MSB+1], wdata[FLAG_LSB-1:ERR_BIT+1]};

  // Detector on/off change refused unless reset disabled and irq masked
  assign guardTrip = strobe.regWr && (wdata[GDIS_BIT] != gdisReg) &&
                     (!rdisReg || bodIrqEn);

  always_ff @(posedge clk or negedge rstCoreN) begin
    if (!rstCoreN) begin
      pmBits  <= '0;
      rpmReg  <= 1'b0;
      gdisReg <= 1'b0;
      rdisReg <= 1'b0;
      errReg  <= 1'b0;
    end else begin
      if (strobe.regWr) begin
        pmBits  <= wdata[PM_LSB+1:PM_LSB];
        rpmReg  <= wdata[RPM_BIT];
        rdisReg <= wdata[RDIS_BIT];
        if (!guardTrip) gdisReg <= wdata[GDIS_BIT];
      end
      if (guardTrip)                              errReg <= 1'b1;
      else if (strobe.regWr && wdata[ERR_BIT])    errReg <= 1'b0;
    end
  end

  // Entry flags: write-one-clear, a new entry wins and clears the rest
  always_comb begin
    flagsNext = flags;
    if (strobe.regWr) flagsNext = flagsNext & ~wdata[FLAG_MSB:FLAG_LSB];
    if (strobe.setFlag) flagsNext = NUM_FLAGS'(1) << strobe.flagMode;
  end

  // Deepest-mode flag lives in the backup domain, the rest in the core domain
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic bitRstN;
    logic flagQ;
    assign bitRstN = (i == NUM_FLAGS - 1) ? rstBackupN : rstCoreN;
    always_ff @(posedge clk or negedge bitRstN) begin
      if (!bitRstN) flagQ <= 1'b0;
      else          flagQ <= flagsNext[i];
    end
    assign flags[i] = flagQ;
  end

  always_comb begin
    rdata = '0;
    if (regHit) begin
      rdata[PM_LSB+1:PM_LSB]  = pmBits;
      rdata[RPM_BIT]          = rpmReg;
      rdata[GDIS_BIT]         = gdisReg;
      rdata[RDIS_BIT]         = rdisReg;
      rdata[ERR_BIT]          = errReg;
      rdata[FLAG_MSB:FLAG_LSB] = flags;
    end
  end

  logic deepGate;
  assign deepGate = rpmReg && lowPowerActive &&
                    (curMode == MODE_DSLEEP || curMode == MODE_PDOWN);

  assign bodEnOut     = !gdisReg && !deepGate;
  assign bodWakeEnOut = bodEnOut && lowPowerActive;
  assign bodRstOut    = bodDetect && bodEnOut && !rdisReg;
  assign bodIrqOut    = bodDetect && bodEnOut && bodIrqEn;

  assert_flags_onehot_R4: assert property (@(posedge clk)
    disable iff (!rstCoreN || !rstBackupN) $onehot0(flags));

  assert_gdis_guard_R10: assert property (@(posedge clk)
    disable iff (!rstCoreN) guardTrip |=> (errReg && gdisReg == $past(gdisReg)));

  assert_gdis_off_R7: assert property (@(posedge clk)
    disable iff (!rstCoreN) gdisReg |-> !(bodEnOut || bodRstOut || bodIrqOut));

  assert_rdis_norst_R9: assert property (@(posedge clk)
    disable iff (!rstCoreN) rdisReg |-> !bodRstOut);

  assert_deep_gate_R8: assert property (@(posedge clk)
    disable iff (!rstCoreN) deepGate |-> (!bodEnOut && !bodWakeEnOut));

endmodule

// File: rtl/powerModeUnit.sv
module powerModeUnit
  import pmuPkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hC0,
  parameter int ACK_WINDOW = 16
) (
  input  logic              clk,
  input  logic              rstCoreN,
  input  logic              rstBackupN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              sleepReq,
  input  logic              deepSleepIn,
  input  logic              pwrAck,
  input  logic              wakeIn,
  output logic              pwrReq,
  output logic [1:0]        pwrMode,
  output logic              lowPowerActive,
  input  logic              bodDetect,
  input  logic              bodIrqEn,
  output logic              bodEnOut,
  output logic              bodWakeEnOut,
  output logic              bodRstOut,
  output logic              bodIrqOut
);

  pmuStrobe_t strobe;
  pmuMode_e   curMode;
  logic       regHit;
  logic [1:0] pmBits;

  pmuControl #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .ACK_WINDOW(ACK_WINDOW)
  ) i_ctl (
    .clk(clk), .rstCoreN(rstCoreN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .sleepReq(sleepReq), .deepSleepIn(deepSleepIn),
    .pwrAck(pwrAck), .wakeIn(wakeIn), .pmBits(pmBits), .strobe(strobe),
    .regHit(regHit), .pwrReq(pwrReq), .curMode(curMode),
    .lowPowerActive(lowPowerActive)
  );

  pmuDatapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstCoreN(rstCoreN), .rstBackupN(rstBackupN), .strobe(strobe),
    .regHit(regHit), .wdata(busWdata), .lowPowerActive(lowPowerActive),
    .curMode(curMode), .bodDetect(bodDetect), .bodIrqEn(bodIrqEn),
    .pmBits(pmBits), .rdata(busRdata), .bodEnOut(bodEnOut),
    .bodWakeEnOut(bodWakeEnOut), .bodRstOut(bodRstOut), .bodIrqOut(bodIrqOut)
  );

  assign pwrMode = curMode;

endmodule

// File: tb/test_powerModeUnit.sv
module test_powerModeUnit;

  localparam logic [7:0] RA = 8'hC0;

  logic clk = 1'b0;
  logic rstCoreN = 1'b0, rstBackupN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic sleepReq = 1'b0, deepSleepIn = 1'b0, pwrAck = 1'b0, wakeIn = 1'b0;
  logic pwrReq, lowPowerActive;
  logic [1:0] pwrMode;
  logic bodDetect = 1'b0, bodIrqEn = 1'b0;
  logic bodEnOut, bodWakeEnOut, bodRstOut, bodIrqOut;

  int checks = 0;
  int failures = 0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  powerModeUnit i_powerModeUnit (
    .clk(clk), .rstCoreN(rstCoreN), .rstBackupN(rstBackupN), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .sleepReq(sleepReq), .deepSleepIn(deepSleepIn),
    .pwrAck(pwrAck), .wakeIn(wakeIn), .pwrReq(pwrReq), .pwrMode(pwrMode),
    .lowPowerActive(lowPowerActive), .bodDetect(bodDetect), .bodIrqEn(bodIrqEn),
    .bodEnOut(bodEnOut), .bodWakeEnOut(bodWakeEnOut), .bodRstOut(bodRstOut),
    .bodIrqOut(bodIrqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares read data against queued expectations
  initial forever begin
    @(negedge clk);
    #2;
    if (busSel && !busWrite && expQ.size() > 0) begin
      automatic logic [31:0] e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      chk(t, busRdata, e);
    end
  end

  task automatic regWrite(input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = RA; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic sleepCycle(input int waitN, input bit giveAck,
                            input logic [1:0] expMode, input string tag);
    @(negedge clk); sleepReq = 1'b1;
    @(negedge clk); sleepReq = 1'b0;
    #1;
    chk({tag, " req"}, 32'(pwrReq), 32'd1);
    chk({tag, " mode"}, 32'(pwrMode), 32'(expMode));
    if (giveAck) begin
      repeat (waitN) @(negedge clk);
      pwrAck = 1'b1;
      @(negedge clk); pwrAck = 1'b0;
      #1;
      chk({tag, " asleep"}, 32'(lowPowerActive), 32'd1);
    end else begin
      repeat (15) @(negedge clk);
      #1;
      chk({tag, " req held at last edge"}, 32'(pwrReq), 32'd1);
      @(negedge clk);
      #1;
      chk({tag, " req dropped"}, 32'(pwrReq), 32'd0);
      chk({tag, " not asleep"}, 32'(lowPowerActive), 32'd0);
    end
  endtask

  task automatic wakeUp();
    @(negedge clk); wakeIn = 1'b1;
    @(negedge clk); wakeIn = 1'b0;
    #1;
    chk("R3 wake", 32'(lowPowerActive), 32'd0);
  endtask

  task automatic pulseCore();
    @(negedge clk); rstCoreN = 1'b0;
    @(negedge clk); rstCoreN = 1'b1;
  endtask

  task automatic pulseBackup();
    @(negedge clk); rstBackupN = 1'b0;
    @(negedge clk); rstBackupN = 1'b1;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstCoreN = 1'b1; rstBackupN = 1'b1;

    // R1 reset state
    regRead(RA, 32'h0, "R1 reset value");
    #1;
    chk("R1 pwrReq", 32'(pwrReq), 32'd0);
    chk("R1 lowPower", 32'(lowPowerActive), 32'd0);
    chk("R1 bodEn", 32'(bodEnOut), 32'd1);
    bodDetect = 1'b1; #1;
    chk("R9 reset enabled", 32'(bodRstOut), 32'd1);
    bodDetect = 1'b0;

    // R11 reserved bits, plus rpm and reset-disable
    regWrite(32'hFFFF_FFD4);
    regRead(RA, 32'h14, "R11 reserved ignored");
    regRead(8'h10, 32'h0, "R11 other address");

    // R9 reset disabled, interrupt passes
    @(negedge clk); bodDetect = 1'b1; bodIrqEn = 1'b1; #1;
    chk("R9 no reset", 32'(bodRstOut), 32'd0);
    chk("R9 irq passes", 32'(bodIrqOut), 32'd1);
    @(negedge clk); bodDetect = 1'b0; bodIrqEn = 1'b0;

    // R7 / R10 guarded detector disable
    regWrite(32'h1C);
    regRead(RA, 32'h1C, "R10 allowed change");
    @(negedge clk); bodDetect = 1'b1; bodIrqEn = 1'b1; #1;
    chk("R7 bodEn off", 32'(bodEnOut), 32'd0);
    chk("R7 irq off", 32'(bodIrqOut), 32'd0);
    @(negedge clk); bodDetect = 1'b0; bodIrqEn = 1'b0;
    regWrite(32'h14);
    regWrite(32'h04);
    regWrite(32'h0C);
    regRead(RA, 32'h24, "R10 blocked by reset enable");
    #1; chk("R10 bodEn kept", 32'(bodEnOut), 32'd1);
    regWrite(32'h24);
    regRead(RA, 32'h04, "R10 error cleared");
    regWrite(32'h14);
    bodIrqEn = 1'b1;
    regWrite(32'h1C);
    regRead(RA, 32'h34, "R10 blocked by irq enable");
    regWrite(32'h34);
    regRead(RA, 32'h14, "R10 error cleared again");
    bodIrqEn = 1'b0;

    // R2 / R3 / R8 mode entries
    deepSleepIn = 1'b1;
    sleepCycle(2, 1'b1, 2'd1, "R2 deep sleep");
    #1;
    chk("R8 deep sleep bodEn", 32'(bodEnOut), 32'd0);
    chk("R8 deep sleep wake", 32'(bodWakeEnOut), 32'd0);
    regRead(RA, 32'h214, "R3 deep sleep flag");
    wakeUp();
    deepSleepIn = 1'b0;
    sleepCycle(0, 1'b1, 2'd0, "R2 sleep");
    #1;
    chk("R8 sleep bodEn", 32'(bodEnOut), 32'd1);
    chk("R8 sleep wake", 32'(bodWakeEnOut), 32'd1);
    regRead(RA, 32'h114, "R4 sleep flag replaces");
    wakeUp();
    regWrite(32'h15);
    sleepCycle(1, 1'b1, 2'd2, "R2 power-down");
    #1; chk("R8 power-down bodEn", 32'(bodEnOut), 32'd0);
    regRead(RA, 32'h415, "R4 power-down flag");
    wakeUp();
    regWrite(32'h12);
    sleepCycle(3, 1'b1, 2'd3, "R2 deep power-down 10");
    #1;
    chk("R8 dpd bodEn", 32'(bodEnOut), 32'd1);
    chk("R8 dpd wake", 32'(bodWakeEnOut), 32'd1);
    regRead(RA, 32'h812, "R4 dpd flag");
    wakeUp();
    regWrite(32'h13);
    sleepCycle(0, 1'b0, 2'd3, "R3 timeout mode 11");
    regRead(RA, 32'h813, "R3 no flag on timeout");
    regWrite(32'h10);
    sleepCycle(15, 1'b1, 2'd0, "R3 ack on last edge");
    regRead(RA, 32'h110, "R3 last-edge flag");
    wakeUp();

    // R5 write-one-clear
    regWrite(32'h010);
    regRead(RA, 32'h110, "R5 zero write keeps flag");
    regWrite(32'h210);
    regRead(RA, 32'h110, "R5 other bit one keeps flag");
    regWrite(32'h110);
    regRead(RA, 32'h010, "R5 one clears flag");

    // R6 reset domains
    regWrite(32'h12);
    sleepCycle(0, 1'b1, 2'd3, "R6 setup dpd");
    wakeUp();
    pulseCore();
    regRead(RA, 32'h800, "R6 core reset keeps bit 11");
    pulseBackup();
    regRead(RA, 32'h0, "R6 backup reset clears bit 11");
    regWrite(32'h10);
    sleepCycle(0, 1'b1, 2'd0, "R6 setup sleep");
    wakeUp();
    pulseBackup();
    regRead(RA, 32'h110, "R6 backup reset keeps bit 8");
    pulseCore();
    regRead(RA, 32'h0, "R6 core reset clears bit 8");

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule